// File: doc/BRIEF.md
# GPIO Pin Drive and Sense Resolver

This block settles, once per clock, what every pin of a general-purpose I/O bank is doing. Each pin brings a 32-bit configuration word, its output latch bit and an external line that is either driven (valid flag and level) or floating. From these the block works out the pin's input value, whether its output driver is active, and the level it presents. It also raises one bank-wide level-sense detect line.

Drive modes that only drive a single polarity gate the output enable on the latch bit. A pull resistor stands in as a weak driver for a floating input. A pin whose input buffer is switched off is pinned to its pull level, and with no pull it keeps the last value it held.

Alongside the resolution the block keeps the previous enable and level of each pin. It pulses a per-pin notification whenever either one changes. It also collects sticky per-pin short-circuit flags, which are cleared by a strobe. All outputs are registered. Every output shows the inputs sampled at the preceding rising edge. The interface has no stream traffic and therefore no back-pressure: every pin is a plain level sampled each cycle.

Top module: `gpio_resolver`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, in_res, oe, oval, notify, short_flag and detect are all 0.
- R2: Drive-mode field cfg[10:8] permits driving as follows: codes 0-3 always, codes 4-5 only while the latch bit is 1, codes 6-7 only while it is 0. The pin drives when the mode permits and direction bit cfg[0] is 1. oe shows this one cycle after the inputs are sampled, unless R4 substitutes a pull.
- R3: Pull field cfg[3:2] is decoded as 2'b01 = pull to 0, 2'b11 = pull to 1, and 2'b00 or 2'b10 = no pull. When cfg[1] is 1 the input buffer is off: in_res takes the pull level, or keeps its previous value when there is no pull.
- R4: When the buffer is on and the external line floats, in_res follows the latch bit if the pin drives. Otherwise a pull makes oe 1, and both oval and in_res take the pull level. With neither, in_res holds, oe is 0 and oval equals the latch bit.
- R5: When the buffer is on and ext_valid is 1, in_res takes ext_level.
- R6: Sense field cfg[17:16] = 2 flags a pin whose buffer is on and whose external line is driven at 1; the value 3 does the same for a line driven at 0. detect is the OR of these flags over all pins.
- R7: A pin whose buffer is on, whose external line is driven and which itself drives a different level sets its short_flag bit. The bit then stays set.
- R8: A cycle with clr_short high clears all short_flag bits. A short detected in that same cycle still sets its bit.
- R9: notify[i] pulses for one cycle exactly when the new oe[i] or oval[i] differs from the value it had in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_flat | input | NPINS*32 | Per-pin configuration words, pin i at bits [32*i+31:32*i] |
| out_latch | input | NPINS | Output latch bit per pin |
| ext_valid | input | NPINS | External line is driven |
| ext_level | input | NPINS | External line level when driven |
| clr_short | input | 1 | Clears the sticky short flags |
| in_res | output | NPINS | Resolved input value |
| oe | output | NPINS | Output driver active |
| oval | output | NPINS | Output level presented |
| notify | output | NPINS | One-cycle change pulse for oe/oval |
| short_flag | output | NPINS | Sticky short-circuit flags |
| detect | output | 1 | Bank-wide sense detect |

## Verification
The clear strobe and a freshly detected short can land in the same cycle. The bench provokes this both in a directed case, with a conflicting drive on pin 0 while clr_short is high, and by asserting clr_short at random during the sweeps. The flag must survive, because setting takes priority over clearing. A second coincidence is a pull substitution that switches oe on in the same cycle in which the latch bit changes oval. It is judged by requiring a single notify pulse that reflects both changes. A near-exhaustive single-pin sweep covers every combination of mode, direction, buffer, pull, sense, latch and external state. A random all-pin phase follows it.

// File: rtl/gpio_res_pkg.sv
`timescale 1ns/1ps
package gpio_res_pkg;
  localparam int CFG_W      = 32;
  localparam int DIR_BIT    = 0;
  localparam int BUFOFF_BIT = 1;
  localparam int PULL_LO    = 2;
  localparam int MODE_LO    = 8;
  localparam int SENSE_LO   = 16;

  typedef enum logic [1:0] {
    PULL_NONE0 = 2'b00,
    PULL_DOWN  = 2'b01,
    PULL_NONE2 = 2'b10,
    PULL_UP    = 2'b11
  } pull_e;

  typedef enum logic [1:0] {
    SENSE_OFF0 = 2'b00,
    SENSE_OFF1 = 2'b01,
    SENSE_HIGH = 2'b10,
    SENSE_LOW  = 2'b11
  } sense_e;

  typedef struct packed {
    logic present;
    logic level;
  } pull_t;

  function automatic logic mode_permits(input logic [2:0] mode, input logic lvl);
    case (mode[2:1])
      2'b10:   return lvl;
      2'b11:   return ~lvl;
      default: return 1'b1;
    endcase
  endfunction

  function automatic pull_t pull_decode(input pull_e p);
    pull_t r;
    r.present = (p == PULL_DOWN) || (p == PULL_UP);
    r.level   = (p == PULL_UP);
    return r;
  endfunction
endpackage

// File: rtl/gpio_pin_resolve.sv
`timescale 1ns/1ps
module gpio_pin_resolve
  import gpio_res_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       dir,
  input  logic       buf_off,
  input  logic [1:0] pull_code,
  input  logic [1:0] sense_code,
  input  logic       out_bit,
  input  logic       ext_v,
  input  logic       ext_l,
  input  logic       in_prev,
  output logic       in_next,
  output logic       conn,
  output logic       lvl,
  output logic       short_now,
  output logic       sense_hit
);
  pull_t  pl;
  sense_e sn;
  logic   drives;

  always_comb begin
    pl        = pull_decode(pull_e'(pull_code));
    sn        = sense_e'(sense_code);
    drives    = mode_permits(mode, out_bit) & dir;
    conn      = drives;
    lvl       = out_bit;
    in_next   = in_prev;
    short_now = 1'b0;
    sense_hit = 1'b0;
    if (buf_off) begin
      if (pl.present) in_next = pl.level;
    end else if (ext_v) begin
      in_next   = ext_l;
      short_now = drives & (out_bit ^ ext_l);
      sense_hit = ((sn == SENSE_HIGH) & ext_l) | ((sn == SENSE_LOW) & ~ext_l);
    end else begin
      if (!drives && pl.present) begin
        conn = 1'b1;
        lvl  = pl.level;
      end
      if (conn) in_next = lvl;
    end
  end
endmodule

// File: rtl/gpio_res_track.sv
`timescale 1ns/1ps
module gpio_res_track #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_short,
  input  logic [NPINS-1:0] in_next,
  input  logic [NPINS-1:0] conn,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] short_now,
  input  logic [NPINS-1:0] sense_hit,
  output logic [NPINS-1:0] in_q,
  output logic [NPINS-1:0] oe_q,
  output logic [NPINS-1:0] oval_q,
  output logic [NPINS-1:0] notify_q,
  output logic [NPINS-1:0] short_q,
  output logic             detect_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q     <= '0;
      oe_q     <= '0;
      oval_q   <= '0;
      notify_q <= '0;
      short_q  <= '0;
      detect_q <= 1'b0;
    end else begin
      in_q     <= in_next;
      oe_q     <= conn;
      oval_q   <= lvl;
      notify_q <= (conn ^ oe_q) | (lvl ^ oval_q);
      short_q  <= (clr_short ? '0 : short_q) | short_now;
      detect_q <= |sense_hit;
    end
  end
endmodule

// File: rtl/gpio_resolver.sv
`timescale 1ns/1ps
module gpio_resolver
  import gpio_res_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS*CFG_W-1:0] cfg_flat,
  input  logic [NPINS-1:0]       out_latch,
  input  logic [NPINS-1:0]       ext_valid,
  input  logic [NPINS-1:0]       ext_level,
  input  logic                   clr_short,
  output logic [NPINS-1:0]       in_res,
  output logic [NPINS-1:0]       oe,
  output logic [NPINS-1:0]       oval,
  output logic [NPINS-1:0]       notify,
  output logic [NPINS-1:0]       short_flag,
  output logic                   detect
);
  logic [NPINS-1:0] in_next, conn, lvl, short_now, sense_hit;
  logic [NPINS-1:0] unused_cfg_bits;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [CFG_W-1:0] w;
    assign w = cfg_flat[i*CFG_W +: CFG_W];
    assign unused_cfg_bits[i] = ^{w[CFG_W-1:SENSE_LO+2], w[SENSE_LO-1:MODE_LO+3],
                                  w[MODE_LO-1:PULL_LO+2]};
    gpio_pin_resolve u_pin (
      .mode       (w[MODE_LO +: 3]),
      .dir        (w[DIR_BIT]),
      .buf_off    (w[BUFOFF_BIT]),
      .pull_code  (w[PULL_LO +: 2]),
      .sense_code (w[SENSE_LO +: 2]),
      .out_bit    (out_latch[i]),
      .ext_v      (ext_valid[i]),
      .ext_l      (ext_level[i]),
      .in_prev    (in_res[i]),
      .in_next    (in_next[i]),
      .conn       (conn[i]),
      .lvl        (lvl[i]),
      .short_now  (short_now[i]),
      .sense_hit  (sense_hit[i])
    );
  end

  gpio_res_track #(.NPINS(NPINS)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_short (clr_short),
    .in_next   (in_next),
    .conn      (conn),
    .lvl       (lvl),
    .short_now (short_now),
    .sense_hit (sense_hit),
    .in_q      (in_res),
    .oe_q      (oe),
    .oval_q    (oval),
    .notify_q  (notify),
    .short_q   (short_flag),
    .detect_q  (detect)
  );
endmodule

// File: rtl/gpio_resolver_chk.sv
`timescale 1ns/1ps
module gpio_resolver_chk
  import gpio_res_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NPINS*CFG_W-1:0] cfg_flat,
  input logic [NPINS-1:0]       out_latch,
  input logic [NPINS-1:0]       ext_valid,
  input logic [NPINS-1:0]       ext_level,
  input logic                   clr_short,
  input logic [NPINS-1:0]       in_res,
  input logic [NPINS-1:0]       oe,
  input logic [NPINS-1:0]       oval,
  input logic [NPINS-1:0]       notify,
  input logic [NPINS-1:0]       short_flag,
  input logic                   detect
);
  logic [NPINS-1:0] c_dir, c_off, c_nopull, c_pdown, c_open_hi;
  logic [NPINS-1:0] unused_chk;

  for (genvar i = 0; i < NPINS; i++) begin : g_c
    logic [CFG_W-1:0] w;
    assign w            = cfg_flat[i*CFG_W +: CFG_W];
    assign c_dir[i]     = w[DIR_BIT];
    assign c_off[i]     = w[BUFOFF_BIT];
    assign c_nopull[i]  = ~w[PULL_LO];
    assign c_pdown[i]   = w[PULL_LO +: 2] == 2'b01;
    assign c_open_hi[i] = w[MODE_LO+2 +: 1] == 1'b1 && w[MODE_LO+1] == 1'b0;
    assign unused_chk[i] = ^{w[CFG_W-1:PULL_LO+2], w[MODE_LO]};

    AST_OE_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!c_dir[i] && c_nopull[i]) |-> !oe[i]); // R2
    AST_OPEN_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(c_dir[i] && c_open_hi[i] && !out_latch[i] && c_off[i]) |-> !oe[i]); // R2
    AST_BUFOFF_PULLDOWN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(c_off[i] && c_pdown[i]) |-> !in_res[i]); // R3
    AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!c_off[i] && ext_valid[i]) |-> in_res[i] == $past(ext_level[i])); // R5
    AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(short_flag[i] && !clr_short) |-> short_flag[i]); // R7
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_short && !ext_valid[i]) |-> !short_flag[i]); // R8
    AST_NOTIFY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      notify[i] |-> (oe[i] != $past(oe[i])) || (oval[i] != $past(oval[i]))); // R9
  end

  AST_DETECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ext_valid == '0) |-> !detect); // R6
endmodule

bind gpio_resolver gpio_resolver_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_flat(cfg_flat), .out_latch(out_latch),
  .ext_valid(ext_valid), .ext_level(ext_level), .clr_short(clr_short),
  .in_res(in_res), .oe(oe), .oval(oval), .notify(notify),
  .short_flag(short_flag), .detect(detect)
);

// File: tb/sim_gpio_resolver.sv
`timescale 1ns/1ps
module sim_gpio_resolver;
  localparam int N = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*32-1:0] cfg_flat = '0;
  logic [N-1:0] out_latch = '0, ext_valid = '0, ext_level = '0;
  logic clr_short = 1'b0;
  logic [N-1:0] in_res, oe, oval, notify, short_flag;
  logic detect;

  int n_cmp = 0, n_bad = 0;
  logic [N-1:0] e_in = '0, e_oe = '0, e_ov = '0, e_nt = '0, e_sh = '0;
  logic e_det = 1'b0;
  logic [N-1:0] in_tag_off, in_tag_ext;

  always #4 clk = ~clk;

  gpio_resolver #(.NPINS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_flat(cfg_flat), .out_latch(out_latch),
    .ext_valid(ext_valid), .ext_level(ext_level), .clr_short(clr_short),
    .in_res(in_res), .oe(oe), .oval(oval), .notify(notify),
    .short_flag(short_flag), .detect(detect)
  );

  task automatic cmp(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Next expected state from the current inputs, built from the requirement text.
  task automatic predict();
    logic [N-1:0] n_in, n_oe, n_ov, n_sh;
    logic det;
    n_in = e_in; n_sh = clr_short ? '0 : e_sh; det = 1'b0;
    for (int i = 0; i < N; i++) begin
      logic [31:0] w;
      logic perm, drv, pp, pl;
      w = cfg_flat[i*32 +: 32];
      case (w[10:8])
        3'd4, 3'd5: perm = out_latch[i];
        3'd6, 3'd7: perm = !out_latch[i];
        default:    perm = 1'b1;
      endcase
      drv = perm && w[0];                       // R2
      pp  = (w[3:2] == 2'b01) || (w[3:2] == 2'b11);
      pl  = (w[3:2] == 2'b11);
      n_oe[i] = drv; n_ov[i] = out_latch[i];
      in_tag_off[i] = w[1]; in_tag_ext[i] = !w[1] && ext_valid[i];
      if (w[1]) begin                           // R3
        if (pp) n_in[i] = pl;
      end else if (ext_valid[i]) begin          // R5
        n_in[i] = ext_level[i];
        if (drv && (out_latch[i] != ext_level[i])) n_sh[i] = 1'b1; // R7
        if ((w[17:16] == 2'd2 && ext_level[i]) || (w[17:16] == 2'd3 && !ext_level[i]))
          det = 1'b1;                           // R6
      end else begin                            // R4
        if (!drv && pp) begin n_oe[i] = 1'b1; n_ov[i] = pl; end
        if (n_oe[i]) n_in[i] = n_ov[i];
      end
    end
    e_nt = (n_oe ^ e_oe) | (n_ov ^ e_ov);       // R9
    e_in = n_in; e_oe = n_oe; e_ov = n_ov; e_sh = n_sh; e_det = det;
  endtask

  task automatic step();
    logic was_clr;
    logic [N-1:0] bad;
    was_clr = clr_short;
    predict();
    @(posedge clk);
    @(negedge clk);
    cmp("R2 oe", oe, e_oe);
    cmp("R4 oval", oval, e_ov);
    cmp("R9 notify", notify, e_nt);
    cmp("R6 detect", {{(N-1){1'b0}}, detect}, {{(N-1){1'b0}}, e_det});
    cmp(was_clr ? "R8 short_flag" : "R7 short_flag", short_flag, e_sh);
    bad = in_res ^ e_in;
    if ((bad & in_tag_off) != 0)      cmp("R3 in_res", in_res, e_in);
    else if ((bad & in_tag_ext) != 0) cmp("R5 in_res", in_res, e_in);
    else                              cmp("R4 in_res", in_res, e_in);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1 reset in_res", in_res, '0);
    cmp("R1 reset oe", oe, '0);
    cmp("R1 reset flags", short_flag | notify | oval, '0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    cmp("R1 after release", in_res | oe | oval | notify | short_flag | {{(N-1){1'b0}}, detect}, '0);

    // Directed: short detected while clearing; the flag must survive (R8).
    cfg_flat[31:0] = 32'h1; out_latch[0] = 1'b1; ext_valid[0] = 1'b1; ext_level[0] = 1'b0;
    step();
    clr_short = 1'b1; step();
    ext_valid[0] = 1'b0; step();
    clr_short = 1'b0; step();

    // Single-pin near-exhaustive sweep, other pins idle with buffer off.
    for (int k = 0; k < 4096; k++) begin
      int p;
      logic [31:0] w;
      p = (k * 7 + k / 64) % N;
      for (int j = 0; j < N; j++) cfg_flat[j*32 +: 32] = 32'h2;
      w = '0;
      w[10:8] = k[2:0]; w[0] = k[3]; w[1] = k[4]; w[3:2] = k[6:5]; w[17:16] = k[8:7];
      cfg_flat[p*32 +: 32] = w;
      out_latch = '0; ext_valid = '0; ext_level = '0;
      out_latch[p] = k[9]; ext_valid[p] = k[10]; ext_level[p] = k[11];
      clr_short = (k % 11) == 0;
      step();
    end

    // Random all-pin phase.
    for (int k = 0; k < 3000; k++) begin
      for (int j = 0; j < N; j++) cfg_flat[j*32 +: 32] = $urandom;
      out_latch = $urandom; ext_valid = $urandom & $urandom; ext_level = $urandom;
      clr_short = ($urandom % 8) == 0;
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule